// File: doc/BRIEF.md
# Indexed Block Register Target on SMBus

This block is an SMBus target that exposes a bank of 8-bit control registers to a bus host. The host writes a run of registers by sending the write address, a starting register index, a byte count and that many data bytes. It reads a run by sending the write address and a starting index, then a repeated START and the read address. The target answers a read with a count byte, taken from a dedicated count register, and then returns consecutive registers until the host withholds its acknowledge.

SCL and SDA are sampled with the system clock. Each line passes through a two-flop synchronizer and a run-length glitch filter. START, repeated START and STOP are then detected on the filtered levels. The target only ever pulls SDA low, through a drive-low enable. It never stretches the clock. The current value of every register, including its read-only fields, is presented on a flat output vector so that the surrounding logic can use it. One register is a deferred register: data written to it is held and applied only when the STOP condition arrives.

Top module: `smb_idx_regslave`

## Requirements
- R1: After reset, index 12 reads 0x0D and indices 2, 3 and 4 read 0xFF. Every other writable bit reads 0, and SDA is not pulled low.
- R2: An address byte of 0xD2 (write) or 0xD3 (read) is acknowledged. Any other address byte is not acknowledged, and every following byte is ignored and not acknowledged until the next START or STOP.
- R3: In a write, the target acknowledges the index byte, the count byte N and N data bytes. The data bytes are stored at consecutive indices starting at the given index. The index steps by one after each byte and wraps from NUM_REGS-1 to 0.
- R4: A count byte of 0 is not acknowledged, and the data that follows is ignored. A data byte beyond the N announced is not acknowledged and is not stored.
- R5: An index byte of NUM_REGS or more is not acknowledged, and the rest of the transaction is ignored.
- R6: After the read address, the target sends the value of index 12 as the count. It then sends registers starting at the current index, with the same step and wrap as R3. It continues for as long as the host acknowledges. A host NACK ends the transfer and SDA is released.
- R7: If the host NACKs and issues STOP before the count is used up, SDA is released. The next transaction then behaves normally.
- R8: A data byte written to index 19 does not change that register until the next STOP. A read of index 19 before that STOP returns the previous value.
- R9: Some bits are read-only and ignore writes. Index 0 bits 7:5 always reflect the 3-bit strap input. Index 7 always reads the ID_BYTE parameter (default 0x15). Index 8 bits 7:4 always read the DEV_ID parameter (default 0x7).
- R10: A pulse on SCL or SDA shorter than FILT_LEN system clocks has no effect on the protocol. The target changes its SDA drive only while the filtered SCL is low.
- R11: Byte i of regFlat (bits 8i+7 down to 8i) always equals what a bus read of index i would return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| strapIn | input | 3 | Strap levels shown in index 0 bits 7:5 |
| sdaDrvLow | output | 1 | When high, the pad pulls SDA low |
| regFlat | output | NUM_REGS*8 | Current read value of every register, index i in byte i |

## Verification
The assertions assume a well-behaved host. SDA changes only while SCL is low, except when the host makes START or STOP. Every intended level is held for much longer than the synchronizer and filter delay, so the target's own SDA change is visible on the filtered line before the next rising edge of SCL. The bench host holds each quarter bit period for eight system clocks and changes SDA only in the middle of the low phase. The only deliberate departure from this is a single-clock SCL dip inside a high phase, which the filter must absorb.

// File: rtl/smb_idx_pkg.sv
package smb_idx_pkg;

  localparam int STRAP_IDX = 0;
  localparam int ID_IDX    = 7;
  localparam int DEVID_IDX = 8;
  localparam int CNT_IDX   = 12;
  localparam int DEFER_IDX = 19;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_OFFS, ST_CNT, ST_WDATA, ST_TXCNT, ST_TXDATA, ST_IGNORE
  } busState_t;

  typedef struct packed {
    logic shiftIn;
    logic loadPtr;
    logic loadCnt;
    logic wrData;
    logic txLoadCnt;
    logic txLoadReg;
    logic txShift;
    logic commit;
  } dpStrobe_t;

  function automatic logic [7:0] roMask(input int idx);
    case (idx)
      STRAP_IDX: roMask = 8'hE0;
      ID_IDX:    roMask = 8'hFF;
      DEVID_IDX: roMask = 8'hF0;
      default:   roMask = 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] resetVal(input int idx);
    if (idx == CNT_IDX) resetVal = 8'h0D;
    else if (idx >= 2 && idx <= 4) resetVal = 8'hFF;
    else resetVal = 8'h00;
  endfunction

endpackage

// File: rtl/smb_line_filter.sv
module smb_line_filter #(
  parameter int LINES    = 2,
  parameter int FILT_LEN = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LINES-1:0] rawIn,
  output logic [LINES-1:0] filtOut
);
  localparam int CW = $clog2(FILT_LEN + 1);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [1:0]    syncQ;
    logic [CW-1:0] runQ;
    logic          levelQ;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        syncQ  <= 2'b11;
        runQ   <= '0;
        levelQ <= 1'b1;
      end else begin
        syncQ <= {syncQ[0], rawIn[g]};
        if (syncQ[1] == levelQ) begin
          runQ <= '0;
        end else if (runQ == CW'(FILT_LEN - 1)) begin
          levelQ <= syncQ[1];
          runQ   <= '0;
        end else begin
          runQ <= runQ + 1'b1;
        end
      end
    end

    assign filtOut[g] = levelQ;
  end

endmodule

// File: rtl/smb_bus_ctrl.sv
module smb_bus_ctrl
  import smb_idx_pkg::*;
#(
  parameter logic [7:0] WR_ADDR = 8'hD2,
  parameter logic [7:0] RD_ADDR = 8'hD3
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclF,
  input  logic      sdaF,
  input  logic [7:0] rxByte,
  input  logic      offsOk,
  input  logic      remainZero,
  input  logic      txMsb,
  output dpStrobe_t strb,
  output logic      sdaDrvLow
);
  busState_t stQ, stD, afterQ, afterD;
  logic [3:0] bitQ, bitD;
  logic ackQ, ackD, txDrvQ, txDrvD, mAckQ, mAckD, armQ, armD;
  logic sclP, sdaP;

  wire sclRise = sclF & ~sclP;
  wire sclFall = ~sclF & sclP;
  wire startEv = sclF & sclP & sdaP & ~sdaF;
  wire stopEv  = sclF & sclP & ~sdaP & sdaF;
  wire isTx    = (stQ == ST_TXCNT) || (stQ == ST_TXDATA);
  wire busy    = (stQ != ST_IDLE) && (stQ != ST_IGNORE);

  always_comb begin
    stD = stQ; bitD = bitQ; ackD = ackQ; txDrvD = txDrvQ;
    afterD = afterQ; mAckD = mAckQ; armD = armQ;
    strb = '0;
    if (stopEv) begin
      stD = ST_IDLE; bitD = '0; ackD = 1'b0; txDrvD = 1'b0;
      strb.commit = 1'b1;
    end else if (startEv) begin
      stD = ST_ADDR; bitD = '0; ackD = 1'b0; txDrvD = 1'b0; armD = 1'b0;
    end else if (busy) begin
      if (sclRise) begin
        if (!isTx && bitQ < 4'd8) strb.shiftIn = 1'b1;
        if (isTx && bitQ == 4'd8) mAckD = ~sdaF;
      end
      if (sclFall) begin
        if (!armQ) begin
          armD = 1'b1;
        end else if (bitQ == 4'd7) begin
          bitD = 4'd8;
          if (isTx) begin
            txDrvD = 1'b0;
          end else begin
            afterD = ST_IGNORE;
            case (stQ)
              ST_ADDR: begin
                if (rxByte == WR_ADDR) begin ackD = 1'b1; afterD = ST_OFFS; end
                else if (rxByte == RD_ADDR) begin ackD = 1'b1; afterD = ST_TXCNT; end
              end
              ST_OFFS: if (offsOk) begin
                ackD = 1'b1; afterD = ST_CNT; strb.loadPtr = 1'b1;
              end
              ST_CNT: if (rxByte != 8'd0) begin
                ackD = 1'b1; afterD = ST_WDATA; strb.loadCnt = 1'b1;
              end
              ST_WDATA: if (!remainZero) begin
                ackD = 1'b1; afterD = ST_WDATA; strb.wrData = 1'b1;
              end
              default: afterD = ST_IGNORE;
            endcase
          end
        end else if (bitQ == 4'd8) begin
          bitD = '0;
          ackD = 1'b0;
          if (isTx) begin
            if (mAckQ) begin
              strb.txLoadReg = 1'b1; txDrvD = 1'b1; stD = ST_TXDATA;
            end else begin
              stD = ST_IGNORE;
            end
          end else begin
            stD = afterQ;
            if (afterQ == ST_TXCNT) begin
              strb.txLoadCnt = 1'b1; txDrvD = 1'b1;
            end
          end
        end else begin
          bitD = bitQ + 4'd1;
          if (isTx) strb.txShift = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stQ <= ST_IDLE; afterQ <= ST_IDLE; bitQ <= '0;
      ackQ <= 1'b0; txDrvQ <= 1'b0; mAckQ <= 1'b0; armQ <= 1'b0;
      sclP <= 1'b1; sdaP <= 1'b1;
    end else begin
      stQ <= stD; afterQ <= afterD; bitQ <= bitD;
      ackQ <= ackD; txDrvQ <= txDrvD; mAckQ <= mAckD; armQ <= armD;
      sclP <= sclF; sdaP <= sdaF;
    end
  end

  assign sdaDrvLow = ackQ | (txDrvQ & ~txMsb);

  // R10: drive changes never happen while SCL is high
  p_drive_scl_low_r10: assert property (@(posedge clk) disable iff (!rstN)
    (sdaDrvLow != $past(sdaDrvLow)) |-> !sclF);

  // R2: acknowledge pulls happen only in the ninth bit slot
  p_ack_slot_r2: assert property (@(posedge clk) disable iff (!rstN)
    ackQ |-> (bitQ == 4'd8));

  // R6: at most one datapath action per cycle
  p_one_strobe_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb));

  // R7: a STOP leaves the line released
  p_release_on_stop_r7: assert property (@(posedge clk) disable iff (!rstN)
    stopEv |=> !sdaDrvLow);

endmodule

// File: rtl/smb_reg_dp.sv
module smb_reg_dp
  import smb_idx_pkg::*;
#(
  parameter int         NUM_REGS = 20,
  parameter logic [7:0] ID_BYTE  = 8'h15,
  parameter logic [3:0] DEV_ID   = 4'h7
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpStrobe_t             strb,
  input  logic                  rxBit,
  input  logic [2:0]            strapIn,
  output logic [7:0]            rxByte,
  output logic                  offsOk,
  output logic                  remainZero,
  output logic                  txMsb,
  output logic [NUM_REGS*8-1:0] regFlat
);
  localparam int PTR_W = $clog2(NUM_REGS);

  logic [7:0] rxSh, txSh, remainQ, pendQ;
  logic       pendV;
  logic [PTR_W-1:0] ptrQ, ptrInc;
  logic [7:0] regQ  [NUM_REGS];
  logic [7:0] rdVal [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_view
    logic [7:0] fixedBits;
    always_comb begin
      if (g == STRAP_IDX)      fixedBits = {strapIn, 5'b0};
      else if (g == ID_IDX)    fixedBits = ID_BYTE;
      else if (g == DEVID_IDX) fixedBits = {DEV_ID, 4'b0};
      else                     fixedBits = 8'h00;
      rdVal[g] = (regQ[g] & ~roMask(g)) | (fixedBits & roMask(g));
    end
    assign regFlat[g*8 +: 8] = rdVal[g];
  end

  assign ptrInc     = (ptrQ == PTR_W'(NUM_REGS - 1)) ? '0 : ptrQ + 1'b1;
  assign rxByte     = rxSh;
  assign offsOk     = 32'(rxSh) < NUM_REGS;
  assign remainZero = (remainQ == 8'd0);
  assign txMsb      = txSh[7];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) regQ[i] <= resetVal(i);
      rxSh <= '0; txSh <= 8'hFF; remainQ <= '0; pendQ <= '0;
      pendV <= 1'b0; ptrQ <= '0;
    end else begin
      if (strb.shiftIn) rxSh <= {rxSh[6:0], rxBit};
      if (strb.loadPtr) ptrQ <= PTR_W'(rxSh);
      if (strb.loadCnt) remainQ <= rxSh;
      if (strb.wrData) begin
        remainQ <= remainQ - 8'd1;
        ptrQ    <= ptrInc;
        if (ptrQ == PTR_W'(DEFER_IDX)) begin
          pendQ <= rxSh;
          pendV <= 1'b1;
        end else begin
          regQ[ptrQ] <= rxSh;
        end
      end
      if (strb.txLoadCnt) txSh <= rdVal[CNT_IDX];
      if (strb.txLoadReg) begin
        txSh <= rdVal[ptrQ];
        ptrQ <= ptrInc;
      end
      if (strb.txShift) txSh <= {txSh[6:0], 1'b1};
      if (strb.commit && pendV) begin
        regQ[DEFER_IDX] <= pendQ;
        pendV <= 1'b0;
      end
    end
  end

  // R3: the pointer stays inside the implemented range
  p_ptr_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    32'(ptrQ) < NUM_REGS);

  // R4: the control never stores more bytes than announced
  p_count_guard_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrData |-> (remainQ != 8'd0));

  // R8: a write aimed at the deferred index leaves it untouched
  p_defer_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrData && ptrQ == PTR_W'(DEFER_IDX)) |=> $stable(regQ[DEFER_IDX]));

endmodule

// File: rtl/smb_idx_regslave.sv
module smb_idx_regslave
  import smb_idx_pkg::*;
#(
  parameter int         NUM_REGS = 20,
  parameter int         FILT_LEN = 3,
  parameter logic [7:0] WR_ADDR  = 8'hD2,
  parameter logic [7:0] RD_ADDR  = 8'hD3,
  parameter logic [7:0] ID_BYTE  = 8'h15,
  parameter logic [3:0] DEV_ID   = 4'h7
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  input  logic [2:0]            strapIn,
  output logic                  sdaDrvLow,
  output logic [NUM_REGS*8-1:0] regFlat
);
  logic [1:0] filtLines;
  dpStrobe_t  strb;
  logic [7:0] rxByte;
  logic       offsOk, remainZero, txMsb;

  smb_line_filter #(.LINES(2), .FILT_LEN(FILT_LEN)) u_filt (
    .clk(clk), .rstN(rstN), .rawIn({sdaIn, sclIn}), .filtOut(filtLines)
  );

  smb_bus_ctrl #(.WR_ADDR(WR_ADDR), .RD_ADDR(RD_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclF(filtLines[0]), .sdaF(filtLines[1]),
    .rxByte(rxByte), .offsOk(offsOk), .remainZero(remainZero), .txMsb(txMsb),
    .strb(strb), .sdaDrvLow(sdaDrvLow)
  );

  smb_reg_dp #(.NUM_REGS(NUM_REGS), .ID_BYTE(ID_BYTE), .DEV_ID(DEV_ID)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rxBit(filtLines[1]), .strapIn(strapIn),
    .rxByte(rxByte), .offsOk(offsOk), .remainZero(remainZero), .txMsb(txMsb),
    .regFlat(regFlat)
  );

endmodule

// File: tb/tb_smb_idx_regslave.sv
module tb_smb_idx_regslave;
  localparam int NR = 20;
  localparam int Q  = 8;
  localparam logic [7:0] ID  = 8'h15;
  localparam logic [3:0] DEV = 4'h7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic mScl = 1'b1, mSda = 1'b1;
  logic [2:0] strap = 3'b101;
  logic sdaDrvLow;
  logic [NR*8-1:0] regFlat;
  wire sdaLine = mSda & ~sdaDrvLow;

  smb_idx_regslave dut (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaLine), .strapIn(strap),
    .sdaDrvLow(sdaDrvLow), .regFlat(regFlat)
  );

  int checks = 0, errors = 0;
  logic [7:0] mdl [NR];
  logic [7:0] wbuf [32];
  logic [7:0] rbuf [32];
  logic [7:0] pendM;
  bit pendMV = 0;

  function automatic logic [7:0] roM(int i);
    if (i == 0) return 8'hE0;
    if (i == 7) return 8'hFF;
    if (i == 8) return 8'hF0;
    return 8'h00;
  endfunction

  function automatic logic [7:0] expRd(int i);
    logic [7:0] fx;
    fx = (i == 0) ? {strap, 5'b0} : (i == 7) ? ID : (i == 8) ? {DEV, 4'b0} : 8'h00;
    return (mdl[i] & ~roM(i)) | (fx & roM(i));
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chkFlat(string tag);
    int bad = 0;
    for (int i = 0; i < NR; i++)
      if (regFlat[i*8 +: 8] !== expRd(i)) begin
        if (bad == 0) begin
          errors++;
          $display("FAIL %s index %0d actual=%0h expected=%0h", tag, i, regFlat[i*8 +: 8], expRd(i));
        end
        bad++;
      end
    checks++;
  endtask

  task automatic modelWrite(int off, int n);
    for (int k = 0; k < n; k++) begin
      int idx = (off + k) % NR;
      if (idx == 19) begin pendM = wbuf[k]; pendMV = 1; end
      else mdl[idx] = wbuf[k];
    end
  endtask

  task automatic modelStop();
    if (pendMV) begin mdl[19] = pendM; pendMV = 0; end
  endtask

  task automatic q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    mSda = 1; q(); mScl = 1; q(); mSda = 0; q(); mScl = 0; q();
  endtask

  task automatic busStop();
    mSda = 0; q(); mScl = 1; q(); mSda = 1; q(); q();
  endtask

  task automatic sendBit(bit b, bit glitch);
    mSda = b; q(); mScl = 1; q();
    if (glitch) begin mScl = 0; @(negedge clk); mScl = 1; end
    q(); mScl = 0; q();
  endtask

  task automatic readBit(output bit b);
    mSda = 1; q(); mScl = 1; q(); b = sdaLine; q(); mScl = 0; q();
  endtask

  task automatic sendByte(logic [7:0] v, bit glitch, output bit ack);
    bit b;
    for (int k = 7; k >= 0; k--) sendBit(v[k], glitch && k == 3);
    readBit(b);
    ack = !b;
  endtask

  task automatic recvByte(bit ackIt, output logic [7:0] v);
    bit b;
    for (int k = 7; k >= 0; k--) begin readBit(b); v[k] = b; end
    sendBit(!ackIt, 0);
  endtask

  task automatic doWrite(logic [7:0] addr, logic [7:0] offB, logic [7:0] cntB,
                         int nData, bit glitch, output logic [35:0] acks);
    bit a;
    acks = '0;
    busStart();
    sendByte(addr, 0, a); acks[0] = a;
    sendByte(offB, 0, a); acks[1] = a;
    sendByte(cntB, glitch, a); acks[2] = a;
    for (int k = 0; k < nData; k++) begin sendByte(wbuf[k], 0, a); acks[3+k] = a; end
    busStop();
  endtask

  task automatic doRead(logic [7:0] offB, int nData, output logic [7:0] cntGot, output bit allAck);
    bit a;
    allAck = 1;
    busStart();
    sendByte(8'hD2, 0, a); allAck &= a;
    sendByte(offB, 0, a);  allAck &= a;
    busStart();
    sendByte(8'hD3, 0, a); allAck &= a;
    recvByte(1, cntGot);
    for (int k = 0; k < nData; k++) recvByte(k != nData - 1, rbuf[k]);
    busStop();
  endtask

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
  end

  initial begin
    logic [35:0] acks;
    logic [7:0] cnt, v, oldV, newV;
    bit allA, a;
    for (int i = 0; i < NR; i++)
      mdl[i] = (i == 12) ? 8'h0D : (i >= 2 && i <= 4) ? 8'hFF : 8'h00;
    repeat (10) @(negedge clk);
    rstN = 1;
    q();

    // R1 reset state
    chk("R1 drive after reset", sdaDrvLow, 0);
    chk("R1 count register", regFlat[12*8 +: 8], 8'h0D);
    chkFlat("R1 reset values (R11 mirror)");

    // R6 full read with wrap
    doRead(0, NR + 2, cnt, allA);
    chk("R6 address acks", allA, 1);
    chk("R6 count byte", cnt, expRd(12));
    for (int k = 0; k < NR + 2; k++) chk("R6 read data", rbuf[k], expRd(k % NR));
    chk("R6 released after read", sdaDrvLow, 0);

    // R3 sweep over every start index, two bytes each, wrap at top
    for (int off = 0; off < NR; off++) begin
      wbuf[0] = 8'((off * 37) ^ 8'hA5);
      wbuf[1] = 8'((off * 11 + 3) ^ 8'h3C);
      doWrite(8'hD2, 8'(off), 8'd2, 2, 0, acks);
      modelWrite(off, 2); modelStop();
      chk("R3 write acks", acks[4:0], 5'b11111);
      chkFlat("R3 stored values (R11 mirror)");
      doRead(8'(off), 2, cnt, allA);
      chk("R6 count after write", cnt, expRd(12));
      chk("R3 readback first", rbuf[0], expRd(off));
      chk("R3 readback wrap", rbuf[1], expRd((off + 1) % NR));
    end

    // R8 deferred commit at STOP
    oldV = expRd(19);
    newV = ~oldV;
    busStart();
    sendByte(8'hD2, 0, a); sendByte(8'd19, 0, a); sendByte(8'd1, 0, a);
    sendByte(newV, 0, a);
    chk("R8 data ack", a, 1);
    busStart();
    sendByte(8'hD2, 0, a); sendByte(8'd19, 0, a);
    busStart();
    sendByte(8'hD3, 0, a);
    recvByte(1, cnt);
    recvByte(0, v);
    chk("R8 read before stop", v, oldV);
    chk("R8 flat before stop", regFlat[19*8 +: 8], oldV);
    busStop();
    chk("R8 flat after stop", regFlat[19*8 +: 8], newV);
    mdl[19] = newV;

    // R4 zero count and excess bytes
    wbuf[0] = 8'h77;
    doWrite(8'hD2, 8'd3, 8'd0, 1, 0, acks);
    chk("R4 zero count acks", acks[3:0], 4'b0011);
    chkFlat("R4 zero count no store");
    wbuf[0] = 8'h81; wbuf[1] = 8'h42;
    doWrite(8'hD2, 8'd5, 8'd1, 2, 0, acks);
    chk("R4 excess byte acks", acks[4:0], 5'b01111);
    modelWrite(5, 1); modelStop();
    chkFlat("R4 excess byte not stored");

    // R2 foreign address
    wbuf[0] = 8'h99;
    doWrite(8'hA4, 8'd2, 8'd1, 1, 0, acks);
    chk("R2 foreign address acks", acks[3:0], 4'b0000);
    chkFlat("R2 foreign address no store");

    // R5 index out of range
    doWrite(8'hD2, 8'(NR), 8'd1, 1, 0, acks);
    chk("R5 range acks", acks[3:0], 4'b0001);
    chkFlat("R5 range no store");

    // R9 read-only fields
    wbuf[0] = 8'hFF; wbuf[1] = 8'h00;
    doWrite(8'hD2, 8'd7, 8'd2, 2, 0, acks);
    modelWrite(7, 2); modelStop();
    wbuf[0] = 8'h00;
    doWrite(8'hD2, 8'd0, 8'd1, 1, 0, acks);
    modelWrite(0, 1); modelStop();
    doRead(8'd7, 2, cnt, allA);
    chk("R9 id byte", rbuf[0], {24'b0, ID});
    chk("R9 device id nibble", rbuf[1][7:4], DEV);
    strap = 3'b010;
    q();
    doRead(8'd0, 1, cnt, allA);
    chk("R9 strap bits", rbuf[0][7:5], 3'b010);
    chkFlat("R9 flat view (R11 mirror)");

    // R7 early end of a read, then a normal write
    doRead(8'd2, 3, cnt, allA);
    chk("R7 early read data", rbuf[2], expRd(4));
    chk("R7 released", sdaDrvLow, 0);
    wbuf[0] = 8'h5E;
    doWrite(8'hD2, 8'd10, 8'd1, 1, 0, acks);
    modelWrite(10, 1); modelStop();
    chk("R7 next transaction acks", acks[3:0], 4'b1111);
    chkFlat("R7 next transaction store");

    // R10 one-clock SCL dip is filtered
    wbuf[0] = 8'hC3;
    doWrite(8'hD2, 8'd11, 8'd1, 1, 1, acks);
    modelWrite(11, 1); modelStop();
    chk("R10 glitch acks", acks[3:0], 4'b1111);
    chkFlat("R10 glitch store");

    report();
  end

endmodule